// File: doc/BRIEF.md
# Byte-Port RAM Disk Controller

This block lets a CPU reach a bank of eight solid-state storage units one byte at a time through two I/O ports. One port is the address port. Each byte written to it shifts into a 22-bit linear address register, so three successive writes set a full address. The other port is the data port. A read returns the byte stored at the current address, a write stores a byte there, and either access then advances the address by one. The address wraps at 2^22, so a long transfer passes from one unit into the next without help from software.

The three top address bits choose the unit and the low bits give the byte offset inside it. Each unit has a present flag and a write-lock flag, driven as static configuration inputs. A read from a missing unit returns an idle-bus value of 0xFF. A write to a missing or locked unit is dropped without any error. The storage is modelled as one inferred RAM per unit. Its depth is a parameter, reduced for simulation, and offsets alias inside that depth. The host side uses a single-cycle request strobe and a one-cycle acknowledge.

Top module: `bytedisk_ctrl`

## Requirements
- R1: Only bit 0 of `io_addr` selects the port: 0 is the data port and 1 is the address port. All other address bits are ignored.
- R2: A write to the address port sets the address to ((address << 8) | byte) mod 2^22. Bytes shifted out above bit 21 are lost.
- R3: Address bits 21..19 select the unit (0..7). Address bits OFS_W-1..0 select the byte inside that unit's storage of 2^OFS_W bytes.
- R4: A data-port read acknowledges two cycles after the request and returns the stored byte. The address advances by one only when that acknowledge is given.
- R5: A data-port write acknowledges one cycle after the request and stores the byte. The address advances by one and wraps from 0x3FFFFF to 0x000000.
- R6: A data-port read from a unit whose `unit_present` bit is 0 returns 0xFF.
- R7: An address-port read acknowledges one cycle after the request, returns 0xFF and leaves the address unchanged.
- R8: A data-port write to a unit whose `unit_present` bit is 0 or whose `unit_wlock` bit is 1 leaves storage unchanged. The address still advances.
- R9: After synchronous reset the address is 0, `io_ack` is 0 and `io_rdata` is 0xFF.
- R10: Every request gets exactly one acknowledge, one cycle wide.
- R11: A change of `unit_present` or `unit_wlock` takes effect on the next data access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | One-cycle request strobe. Allowed only while no request is outstanding. |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O address. Only bit 0 is decoded. |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte. Valid while `io_ack` is high. |
| io_ack | output | 1 | One-cycle completion pulse |
| unit_present | input | 8 | Present flag, one bit per unit |
| unit_wlock | input | 8 | Write-lock flag, one bit per unit |

## Verification
The hardest cases to reach are a data transfer that crosses from one unit into the next and a transfer that wraps from the top of the 22-bit space to zero. Each needs a three- or four-byte address load that puts the address just below a boundary. The bench loads those addresses directly, bursts writes across the boundary and reads them back. Randomly mixed traffic, with present and lock flags changing between accesses, is compared against a bench model of the address register and the storage.

// File: rtl/bdk_pkg.sv
package bdk_pkg;
  localparam int ADDR_W     = 22;
  localparam int NUM_UNITS  = 8;
  localparam int USEL_W     = $clog2(NUM_UNITS);
  localparam int UNIT_LSB   = ADDR_W - USEL_W;
  localparam int BYTE_W     = 8;
  localparam logic [BYTE_W-1:0] IDLE_BUS = 8'hFF;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_RDWAIT = 1'b1
  } fsm_state_t;
endpackage

// File: rtl/bdk_addr_reg.sv
module bdk_addr_reg
  import bdk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              step_en,
  input  logic [BYTE_W-1:0] shift_byte,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (shift_en) begin
      addr <= {addr[ADDR_W-BYTE_W-1:0], shift_byte};
    end else if (step_en) begin
      addr <= addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/bdk_unit_bank.sv
module bdk_unit_bank
  import bdk_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_we,
  input  logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] mem_rdata
);
  localparam int DEPTH = 1 << OFS_W;

  logic [USEL_W-1:0] sel;
  logic [OFS_W-1:0]  ofs;
  logic [USEL_W-1:0] sel_q;
  logic [BYTE_W-1:0] rd_arr [NUM_UNITS];

  assign sel = mem_addr[ADDR_W-1 -: USEL_W];
  assign ofs = mem_addr[OFS_W-1:0];

  logic unused_mid;
  assign unused_mid = &{1'b0, mem_addr[UNIT_LSB-1:OFS_W]};

  always_ff @(posedge clk) sel_q <= sel;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [BYTE_W-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (mem_we && sel == USEL_W'(u)) ram[ofs] <= mem_wdata;
      rd_arr[u] <= ram[ofs];
    end
  end

  assign mem_rdata = rd_arr[sel_q];
endmodule

// File: rtl/bdk_port_fsm.sv
module bdk_port_fsm
  import bdk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_req,
  input  logic                 io_wr,
  input  logic                 io_sel,
  input  logic [BYTE_W-1:0]    io_wdata,
  output logic [BYTE_W-1:0]    io_rdata,
  output logic                 io_ack,
  input  logic [NUM_UNITS-1:0] unit_present,
  input  logic [NUM_UNITS-1:0] unit_wlock,
  input  logic [ADDR_W-1:0]    cur_addr,
  output logic                 shift_en,
  output logic                 step_en,
  output logic                 mem_we,
  output logic [BYTE_W-1:0]    mem_wdata,
  input  logic [BYTE_W-1:0]    mem_rdata
);
  fsm_state_t        state;
  logic              rd_present_q;
  logic [USEL_W-1:0] unit;
  logic              data_rd, data_wr, addr_rd;

  assign unit    = cur_addr[ADDR_W-1 -: USEL_W];
  assign data_rd = (state == ST_IDLE) && io_req && !io_wr && !io_sel;
  assign data_wr = (state == ST_IDLE) && io_req &&  io_wr && !io_sel;
  assign addr_rd = (state == ST_IDLE) && io_req && !io_wr &&  io_sel;

  assign shift_en  = (state == ST_IDLE) && io_req && io_wr && io_sel;
  assign step_en   = data_wr || (state == ST_RDWAIT);
  assign mem_we    = data_wr && unit_present[unit] && !unit_wlock[unit];
  assign mem_wdata = io_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      io_ack       <= 1'b0;
      io_rdata     <= IDLE_BUS;
      rd_present_q <= 1'b0;
    end else begin
      io_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (data_rd) begin
            rd_present_q <= unit_present[unit];
            state        <= ST_RDWAIT;
          end else if (shift_en || data_wr || addr_rd) begin
            io_ack   <= 1'b1;
            io_rdata <= IDLE_BUS;
          end
        end
        ST_RDWAIT: begin
          io_ack   <= 1'b1;
          io_rdata <= rd_present_q ? mem_rdata : IDLE_BUS;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bytedisk_ctrl.sv
module bytedisk_ctrl
  import bdk_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter int OFS_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_req,
  input  logic                 io_wr,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic [BYTE_W-1:0]    io_wdata,
  output logic [BYTE_W-1:0]    io_rdata,
  output logic                 io_ack,
  input  logic [NUM_UNITS-1:0] unit_present,
  input  logic [NUM_UNITS-1:0] unit_wlock
);
  logic [ADDR_W-1:0] addr_q;
  logic              shift_en, step_en, mem_we;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  logic unused_io;
  assign unused_io = &{1'b0, io_addr[IO_AW-1:1]};

  bdk_port_fsm u_fsm (
    .clk(clk), .rst(rst),
    .io_req(io_req), .io_wr(io_wr), .io_sel(io_addr[0]),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .unit_present(unit_present), .unit_wlock(unit_wlock),
    .cur_addr(addr_q), .shift_en(shift_en), .step_en(step_en),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  bdk_addr_reg u_addr (
    .clk(clk), .rst(rst), .shift_en(shift_en), .step_en(step_en),
    .shift_byte(io_wdata), .addr(addr_q)
  );

  bdk_unit_bank #(.OFS_W(OFS_W)) u_bank (
    .clk(clk), .mem_addr(addr_q), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/bdk_checker.sv
module bdk_checker
  import bdk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic              io_wr,
  input logic              io_sel,
  input logic [BYTE_W-1:0] io_wdata,
  input logic [BYTE_W-1:0] io_rdata,
  input logic              io_ack,
  input logic [ADDR_W-1:0] cur_addr
);
  AST_ADDR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_wr && io_sel) |=> cur_addr == {$past(cur_addr[ADDR_W-BYTE_W-1:0]), $past(io_wdata)}); // R2
  AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_wr && !io_sel) |=> io_ack && cur_addr == ADDR_W'($past(cur_addr) + 1)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_wr && !io_sel) |=> !io_ack && $stable(cur_addr)); // R4
  AST_ADDR_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_wr && io_sel) |=> io_ack && io_rdata == IDLE_BUS && $stable(cur_addr)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    io_ack |=> !io_ack); // R10
endmodule

bind bytedisk_ctrl bdk_checker u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_sel(io_addr[0]),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack), .cur_addr(addr_q)
);

// File: tb/bytedisk_ctrl_test.sv
module bytedisk_ctrl_test;
  localparam int OFS_W = 6;
  localparam int DEPTH = 1 << OFS_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_req = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       io_ack;
  logic [7:0] unit_present = 8'hFF, unit_wlock = 8'h00;

  int checks = 0, errors = 0;
  logic [21:0] m_addr;
  logic [7:0]  ref_mem [8][DEPTH];

  always #4 clk = ~clk;

  bytedisk_ctrl #(.IO_AW(8), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .unit_present(unit_present), .unit_wlock(unit_wlock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [21:0] a);
    if (!unit_present[a[21:19]]) return 8'hFF;
    return ref_mem[a[21:19]][a[OFS_W-1:0]];
  endfunction

  // one bus operation; returns latency in cycles and the read byte
  task automatic bus_op(input logic [7:0] ioa, input logic wr, input logic [7:0] d,
                        output int lat, output logic [7:0] rd);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = ioa; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0;
    lat = 1;
    while (!io_ack && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    rd = io_rdata;
  endtask

  task automatic addr_byte(input logic [7:0] b, input logic [7:0] ioa = 8'h01);
    int lat; logic [7:0] rd;
    bus_op(ioa, 1'b1, b, lat, rd);
    m_addr = {m_addr[13:0], b};
    chk("R2 addr ack", lat, 1);
  endtask

  task automatic load_addr(input logic [21:0] a);
    addr_byte({2'b00, a[21:16]});
    addr_byte(a[15:8]);
    addr_byte(a[7:0]);
  endtask

  task automatic data_wr(input logic [7:0] d, input logic [7:0] ioa = 8'h00);
    int lat; logic [7:0] rd;
    bus_op(ioa, 1'b1, d, lat, rd);
    if (unit_present[m_addr[21:19]] && !unit_wlock[m_addr[21:19]])
      ref_mem[m_addr[21:19]][m_addr[OFS_W-1:0]] = d;
    m_addr = m_addr + 22'd1;
    chk("R5 write ack latency", lat, 1);
  endtask

  task automatic data_rd(input string req, input logic [7:0] ioa = 8'h00);
    int lat; logic [7:0] rd; logic [7:0] e;
    e = exp_read(m_addr);
    bus_op(ioa, 1'b0, 8'h00, lat, rd);
    m_addr = m_addr + 22'd1;
    chk("R4 read ack latency", lat, 2);
    chk(req, rd, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int lat; logic [7:0] rd;
    void'($urandom(32'd20240611));
    m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset ack", io_ack, 0);
    chk("R9 reset rdata", io_rdata, 8'hFF);
    rst = 1'b0;

    // R9: address zero after reset, seen by a write then reload
    data_wr(8'h3C);
    load_addr(22'h0);
    data_rd("R9 reset address zero");

    // fill every unit (R3 unit select)
    for (int u = 0; u < 8; u++) begin
      m_addr = '0;
      load_addr(22'(u) << 19);
      for (int i = 0; i < DEPTH; i++) data_wr(8'((u * 37 + i * 11) ^ 8'h5A));
    end
    for (int u = 0; u < 8; u++) begin
      load_addr((22'(u) << 19) + 22'd5);
      data_rd("R3 unit and offset select");
    end

    // R2: four bytes, top one shifted out; R1 upper address bits ignored
    addr_byte(8'hAB, 8'hF3);
    addr_byte(8'h07, 8'h11);
    addr_byte(8'hFF);
    addr_byte(8'hFC);
    chk("R2 model address", m_addr, 22'h07FFFC);
    unit_present = 8'h03;
    for (int i = 0; i < 8; i++) data_wr(8'hC0 + 8'(i), 8'hFE);   // R1 data port, high bits set
    load_addr(22'h07FFFC);
    for (int i = 0; i < 8; i++) data_rd("R5 burst crosses unit boundary", 8'h40);

    // R7 address port read: FF, no address change
    load_addr(22'h080001);
    bus_op(8'h01, 1'b0, 8'h00, lat, rd);
    chk("R7 address port read value", rd, 8'hFF);
    chk("R7 address port read ack", lat, 1);
    data_rd("R7 address unchanged");

    // R8 locked unit
    unit_wlock = 8'h02;
    load_addr(22'h080000);
    data_wr(8'h11); data_wr(8'h22);
    chk("R8 address still advances", m_addr, 22'h080002);
    data_rd("R8 locked cell after skip");
    load_addr(22'h080000);
    data_rd("R8 locked unit unchanged");
    data_rd("R8 locked unit unchanged");

    // R6/R8 absent unit
    unit_wlock = 8'h00;
    load_addr(22'h100000);
    data_wr(8'h77);
    load_addr(22'h100000);
    data_rd("R6 absent unit reads FF");
    unit_present = 8'hFF;                                    // R11 takes effect next access
    load_addr(22'h100000);
    data_rd("R8 absent write left storage");

    // R5 wrap
    unit_present = 8'h81;
    load_addr(22'h3FFFFF);
    data_wr(8'hA5);
    chk("R5 wrap to zero", m_addr, 22'h0);
    data_wr(8'h5A);
    load_addr(22'h3FFFFF);
    data_rd("R5 top byte");
    data_rd("R5 wrapped byte");

    // random mix, R10 and R11 across changing config
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 99));
      if (n % 25 == 0) begin
        unit_present = 8'($urandom());
        unit_wlock   = 8'($urandom());
      end
      if (k < 15)      addr_byte(8'($urandom()), 8'($urandom()) | 8'h01);
      else if (k < 20) begin
        bus_op(8'h01, 1'b0, 8'h00, lat, rd);
        chk("R7 random address read", rd, 8'hFF);
      end
      else if (k < 60) data_wr(8'($urandom()), 8'($urandom()) & 8'hFE);
      else             data_rd("R11 random read vs model", 8'($urandom()) & 8'hFE);
      if (n % 100 == 0) begin
        @(negedge clk);
        chk("R10 ack one cycle", io_ack, 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule